// File: doc/BRIEF.md
# Raster Framebuffer Scan-out Engine

This block drives a raster display from a packed-index frame buffer. Free-running horizontal and vertical counters produce the sync pulses, a display-enable flag and strobes that mark the first clock of each line and of each frame. During the visible region the block emits one 8-bit colour-lookup index per pixel clock. A palette stage downstream turns that index into colour.

Pixel indices are fetched from a 32-bit-wide video memory through a read port with a request, an address, and a data-valid return. The return latency may be any number of cycles. Every word carries four indices, and the most significant byte is shown first. Stored lines are wider than the visible width, so at the end of each visible line the read address jumps over the unused words to the start of the next stored line. A small prefetch FIFO with credit-based issue keeps data ahead of the raster.

By default the visible area is 1280 x 1024, with 1680 clocks per line and 1063 lines per frame, at a 125 MHz pixel clock. The stored line pitch is 512 words. Every count can be changed through a parameter.

Top module: `fb_scanout`

## Requirements
- R1: Each line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks, 1680 by default. `line_start_o` pulses for one clock on the first clock of every line, blanking lines included.
- R2: Each frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines, 1063 by default. `frame_start_o` pulses on the first clock of the first line, together with `line_start_o`.
- R3: `hsync_o` is high, with active-high polarity, for H_SYNC clocks. It starts H_FP clocks after the last visible pixel of the line.
- R4: `vsync_o` is high for the whole of V_SYNC lines. These start V_FP lines after the last visible line.
- R5: Four consecutive pixels come from one memory word, in this order: bits 31:24, then 23:16, then 15:8, then 7:0. H_ACTIVE is a multiple of 4.
- R6: Visible pixel x of visible line y shows the word at address y*PITCH_WORDS + x/4, where PITCH_WORDS is at least H_ACTIVE/4. The words between the end of a visible line and the next pitch boundary are never shown.
- R7: `pix_o` is 0 whenever `de_o` is low. `de_o` is high only in the first H_ACTIVE clocks of the first V_ACTIVE lines.
- R8: While `rst` is high, all outputs are 0 and no read is requested. The clock after the first edge with `rst` low shows `frame_start_o` and `line_start_o` high, with the counters at the top-left pixel.
- R9: The first frame after reset is fully blanked, with `de_o` low. From the second frame on, the top-left visible pixel comes from word 0.
- R10: Reads in flight plus words held never exceed FIFO_DEPTH. The FIFO never underflows, for any constant read latency up to FIFO_DEPTH-1 cycles, so every visible pixel is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_o | output | 1 | Read request to video memory |
| rd_addr_o | output | ADDR_W | Word address of the request |
| rd_data_i | input | 32 | Returned memory word |
| rd_valid_i | input | 1 | Returned word valid, once per request, in order |
| pix_o | output | 8 | Colour-lookup index |
| de_o | output | 1 | Display enable |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| line_start_o | output | 1 | First clock of a line |
| frame_start_o | output | 1 | First clock of a frame |

## Verification
The hardest case to reach is the hand-off from one frame to the next. The fetcher must rewind to word 0 during vertical blanking, and only after every word of the previous frame has been consumed. The fetcher must also start cleanly after a reset taken in the middle of a line, while reads are still in flight. The stimulus uses a scaled-down raster with a three-cycle memory so that several frame boundaries fit in a short run. A second reset is asserted partway through a visible line, and the next session must again start from word 0 after one blank frame.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    localparam int WORD_W        = 32;
    localparam int PIX_W         = 8;
    localparam int PIX_PER_WORD  = WORD_W / PIX_W;

    // Leftmost pixel sits in the most significant byte.
    function automatic logic [PIX_W-1:0] pick_pixel(input logic [WORD_W-1:0] w,
                                                    input logic [1:0] phase);
        logic [PIX_W-1:0] r;
        case (phase)
            2'd0:    r = w[31:24];
            2'd1:    r = w[23:16];
            2'd2:    r = w[15:8];
            default: r = w[7:0];
        endcase
        return r;
    endfunction
endpackage

// File: rtl/fbs_timing.sv
module fbs_timing #(
    parameter int H_ACTIVE = 1280,
    parameter int H_FP     = 32,
    parameter int H_SYNC   = 128,
    parameter int H_BP     = 240,
    parameter int V_ACTIVE = 1024,
    parameter int V_FP     = 3,
    parameter int V_SYNC   = 3,
    parameter int V_BP     = 33,
    parameter int HW       = 11,
    parameter int VW       = 11
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] h_o,
    output logic          active_o,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          line_first_o,
    output logic          frame_first_o,
    output logic          frame_last_o,
    output logic          vblank_o
);
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] H_VIS   = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_VIS   = VW'(V_ACTIVE);
    localparam logic [HW-1:0] HS_BEG  = HW'(H_ACTIVE + H_FP);
    localparam logic [HW-1:0] HS_END  = HW'(H_ACTIVE + H_FP + H_SYNC);
    localparam logic [VW-1:0] VS_BEG  = VW'(V_ACTIVE + V_FP);
    localparam logic [VW-1:0] VS_END  = VW'(V_ACTIVE + V_FP + V_SYNC);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } tim_t;

    tim_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.h == H_LAST) begin
            nxt_d.h = '0;
            nxt_d.v = (cur_q.v == V_LAST) ? '0 : cur_q.v + 1'b1;
        end else begin
            nxt_d.h = cur_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign h_o           = cur_q.h;
    assign active_o      = (cur_q.h < H_VIS) && (cur_q.v < V_VIS);
    assign hsync_o       = (cur_q.h >= HS_BEG) && (cur_q.h < HS_END);
    assign vsync_o       = (cur_q.v >= VS_BEG) && (cur_q.v < VS_END);
    assign line_first_o  = (cur_q.h == '0);
    assign frame_first_o = (cur_q.h == '0) && (cur_q.v == '0);
    assign frame_last_o  = (cur_q.h == H_LAST) && (cur_q.v == V_LAST);
    assign vblank_o      = (cur_q.v >= V_VIS);

    assert_hcount_bound_R1: assert property (@(posedge clk) disable iff (rst)
        cur_q.h <= H_LAST);
    assert_vcount_step_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_q.h == H_LAST && cur_q.v != V_LAST) |=> (cur_q.v == $past(cur_q.v) + 1'b1));
endmodule

// File: rtl/fbs_fifo.sv
module fbs_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic [W-1:0]  din_i,
    input  logic          pop_i,
    output logic [W-1:0]  head_o,
    output logic [CW-1:0] count_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t st_q, st_d;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push_i) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (pop_i)  st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem_q[st_q.wp] <= din_i;
    end

    assign head_o  = mem_q[st_q.rp];
    assign count_o = st_q.cnt;

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i) |-> (st_q.cnt < FULL));
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> (st_q.cnt != '0));
endmodule

// File: rtl/fbs_fetch.sv
module fbs_fetch #(
    parameter int ADDR_W      = 20,
    parameter int WORDS_LINE  = 320,
    parameter int PITCH_WORDS = 512,
    parameter int LINES       = 1024,
    parameter int DEPTH       = 8,
    parameter int CW          = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vblank_i,
    input  logic [CW-1:0]     fifo_cnt_i,
    input  logic              rd_valid_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o
);
    localparam int WLW = (WORDS_LINE > 1) ? $clog2(WORDS_LINE) : 1;
    localparam int LNW = (LINES > 1) ? $clog2(LINES) : 1;
    localparam logic [WLW-1:0]    WORD_LAST = WLW'(WORDS_LINE - 1);
    localparam logic [LNW-1:0]    LINE_LAST = LNW'(LINES - 1);
    localparam logic [ADDR_W-1:0] SKIP      = ADDR_W'(PITCH_WORDS - WORDS_LINE + 1);
    localparam logic [CW:0]       CAP       = (CW+1)'(DEPTH);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WLW-1:0]    word;
        logic [LNW-1:0]    line;
        logic [CW-1:0]     inflight;
        logic              done;
    } fetch_t;

    fetch_t st_q, st_d;
    logic   issue, restart;
    logic [CW:0] used;

    always_comb begin
        used    = {1'b0, fifo_cnt_i} + {1'b0, st_q.inflight};
        issue   = !st_q.done && (used < CAP);
        restart = st_q.done && vblank_i && (fifo_cnt_i == '0) && (st_q.inflight == '0);
        st_d    = st_q;

        case ({issue, rd_valid_i})
            2'b10:   st_d.inflight = st_q.inflight + 1'b1;
            2'b01:   st_d.inflight = st_q.inflight - 1'b1;
            default: st_d.inflight = st_q.inflight;
        endcase

        if (restart) begin
            st_d.addr = '0;
            st_d.word = '0;
            st_d.line = '0;
            st_d.done = 1'b0;
        end else if (issue) begin
            if (st_q.word == WORD_LAST) begin
                st_d.word = '0;
                st_d.addr = st_q.addr + SKIP;
                if (st_q.line == LINE_LAST) begin
                    st_d.line = '0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.line = st_q.line + 1'b1;
                end
            end else begin
                st_d.word = st_q.word + 1'b1;
                st_d.addr = st_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.done <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_req_o  = issue;
    assign rd_addr_o = st_q.addr;

    assert_credit_bound_R10: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, fifo_cnt_i} + {1'b0, st_q.inflight}) <= CAP);
    assert_rewind_to_zero_R9: assert property (@(posedge clk) disable iff (rst)
        restart |=> (rd_addr_o == '0));
    assert_no_return_unasked_R10: assert property (@(posedge clk) disable iff (rst)
        rd_valid_i |-> (st_q.inflight != '0));
endmodule

// File: rtl/fb_scanout.sv
module fb_scanout #(
    parameter int ADDR_W      = 20,
    parameter int H_ACTIVE    = 1280,
    parameter int H_FP        = 32,
    parameter int H_SYNC      = 128,
    parameter int H_BP        = 240,
    parameter int V_ACTIVE    = 1024,
    parameter int V_FP        = 3,
    parameter int V_SYNC      = 3,
    parameter int V_BP        = 33,
    parameter int PITCH_WORDS = 512,
    parameter int FIFO_DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [31:0]       rd_data_i,
    input  logic              rd_valid_i,
    output logic [7:0]        pix_o,
    output logic              de_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              line_start_o,
    output logic              frame_start_o
);
    import fbs_pkg::*;

    localparam int H_TOTAL    = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL    = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HW         = $clog2(H_TOTAL);
    localparam int VW         = $clog2(V_TOTAL);
    localparam int WORDS_LINE = H_ACTIVE / PIX_PER_WORD;
    localparam int CW         = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic [PIX_W-1:0]  pix;
        logic              de;
        logic              hs;
        logic              vs;
        logic              ls;
        logic              fs;
        logic [WORD_W-1:0] word;
        logic              primed;
    } out_t;

    out_t o_q, o_d;

    logic [HW-1:0]     h;
    logic              active, hs_raw, vs_raw, lfirst, ffirst, flast, vblank;
    logic              pop;
    logic [WORD_W-1:0] head;
    logic [CW-1:0]     fifo_cnt;

    fbs_timing #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .HW(HW), .VW(VW)
    ) u_timing (
        .clk(clk), .rst(rst), .h_o(h), .active_o(active),
        .hsync_o(hs_raw), .vsync_o(vs_raw), .line_first_o(lfirst),
        .frame_first_o(ffirst), .frame_last_o(flast), .vblank_o(vblank)
    );

    fbs_fetch #(
        .ADDR_W(ADDR_W), .WORDS_LINE(WORDS_LINE), .PITCH_WORDS(PITCH_WORDS),
        .LINES(V_ACTIVE), .DEPTH(FIFO_DEPTH), .CW(CW)
    ) u_fetch (
        .clk(clk), .rst(rst), .vblank_i(vblank), .fifo_cnt_i(fifo_cnt),
        .rd_valid_i(rd_valid_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o)
    );

    fbs_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W), .CW(CW)) u_fifo (
        .clk(clk), .rst(rst), .push_i(rd_valid_i), .din_i(rd_data_i),
        .pop_i(pop), .head_o(head), .count_o(fifo_cnt)
    );

    always_comb begin
        pop = o_q.primed && active && (h[1:0] == 2'd0);
        o_d = o_q;
        o_d.hs = hs_raw;
        o_d.vs = vs_raw;
        o_d.ls = lfirst;
        o_d.fs = ffirst;
        o_d.de = active && o_q.primed;
        if (pop)       o_d.word = head;
        if (pop)       o_d.pix  = pick_pixel(head, 2'd0);
        else if (o_d.de) o_d.pix = pick_pixel(o_q.word, h[1:0]);
        else           o_d.pix  = '0;
        if (flast) o_d.primed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) o_q <= '0;
        else     o_q <= o_d;
    end

    assign pix_o         = o_q.pix;
    assign de_o          = o_q.de;
    assign hsync_o       = o_q.hs;
    assign vsync_o       = o_q.vs;
    assign line_start_o  = o_q.ls;
    assign frame_start_o = o_q.fs;

    assert_blank_index_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !de_o |-> (pix_o == '0));
    assert_frame_with_line_R2: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> line_start_o);
    assert_de_not_in_sync_R3: assert property (@(posedge clk) disable iff (rst)
        hsync_o |-> !de_o);
    assert_reset_quiet_R8: assert property (@(posedge clk)
        $past(rst) |-> (!de_o && pix_o == '0));
endmodule

// File: tb/sim_fb_scanout.sv
`timescale 1ns/1ps
module sim_fb_scanout;
    localparam int HA = 16, HFP = 2, HSY = 3, HBP = 5;
    localparam int VA = 4,  VFP = 1, VSY = 2, VBP = 1;
    localparam int HT = HA + HFP + HSY + HBP;
    localparam int VT = VA + VFP + VSY + VBP;
    localparam int PITCH = 8;
    localparam int AW = 12;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          rd_req, rd_valid;
    logic [AW-1:0] rd_addr;
    logic [31:0]   rd_data;
    logic [7:0]    pix;
    logic          de, hs, vs, ls, fs;

    fb_scanout #(
        .ADDR_W(AW), .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP),
        .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP),
        .PITCH_WORDS(PITCH), .FIFO_DEPTH(8)
    ) u0 (
        .clk(clk), .rst(rst), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
        .rd_data_i(rd_data), .rd_valid_i(rd_valid), .pix_o(pix), .de_o(de),
        .hsync_o(hs), .vsync_o(vs), .line_start_o(ls), .frame_start_o(fs)
    );

    function automatic logic [31:0] pat(input int a);
        logic [7:0] b = 8'(a);
        return {b, ~b, 8'(a >> 3) ^ 8'h3C, b ^ 8'hC3};
    endfunction

    // behavioural memory with a fixed return latency
    logic [AW-1:0] lat_a [LAT];
    logic          lat_v [LAT];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) lat_v[i] <= 1'b0;
        end else begin
            lat_v[0] <= rd_req;
            lat_a[0] <= rd_addr;
            for (int i = 1; i < LAT; i++) begin
                lat_v[i] <= lat_v[i-1];
                lat_a[i] <= lat_a[i-1];
            end
        end
    end
    assign rd_valid = lat_v[LAT-1];
    assign rd_data  = lat_v[LAT-1] ? pat(int'(lat_a[LAT-1])) : 32'h0;

    typedef struct {
        logic [7:0] p;
        logic de, hs, vs, ls, fs;
        int x, y;
    } item_t;
    item_t sb[$];

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: expected raster for nf displayed frames
    task automatic push_frames(input int nf);
        for (int f = 0; f < nf; f++)
            for (int y = 0; y < VT; y++)
                for (int x = 0; x < HT; x++) begin
                    item_t it;
                    logic [31:0] w;
                    it.x  = x; it.y = y;
                    it.de = (x < HA) && (y < VA);                           // R7
                    w     = pat(y * PITCH + x / 4);                         // R6
                    it.p  = it.de ? w[31 - 8 * (x % 4) -: 8] : 8'h00;       // R5
                    it.hs = (x >= HA + HFP) && (x < HA + HFP + HSY);        // R3
                    it.vs = (y >= VA + VFP) && (y < VA + VFP + VSY);        // R4
                    it.ls = (x == 0);                                       // R1
                    it.fs = (x == 0) && (y == 0);                           // R2
                    sb.push_back(it);
                end
    endtask

    // monitor: one scoreboard item per clock
    task automatic consume();
        while (sb.size() != 0) begin
            item_t e;
            @(negedge clk);
            e = sb.pop_front();
            if (e.de && pix !== e.p)
                chk(0, "R5 R6", $sformatf("pix x=%0d y=%0d", e.x, e.y), pix, e.p);
            else if (de !== e.de || (!e.de && pix !== 8'h00))
                chk(0, "R7", $sformatf("de/pix x=%0d y=%0d", e.x, e.y), {de, pix}, {e.de, e.p});
            else if (hs !== e.hs)
                chk(0, "R3", $sformatf("hsync x=%0d y=%0d", e.x, e.y), hs, e.hs);
            else if (vs !== e.vs)
                chk(0, "R4", $sformatf("vsync x=%0d y=%0d", e.x, e.y), vs, e.vs);
            else if (ls !== e.ls)
                chk(0, "R1", $sformatf("line_start x=%0d y=%0d", e.x, e.y), ls, e.ls);
            else if (fs !== e.fs)
                chk(0, "R2", $sformatf("frame_start x=%0d y=%0d", e.x, e.y), fs, e.fs);
            else
                chk(1, "R1", "", 0, 0);
        end
    endtask

    task automatic session(input int nf);
        int de_seen;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(de === 1'b0 && pix === 8'h00, "R8", "outputs quiet in reset", {de, pix}, 0);
        chk(fs === 1'b0 && ls === 1'b0 && hs === 1'b0 && vs === 1'b0, "R8",
            "strobes low in reset", {fs, ls, hs, vs}, 0);
        chk(rd_req === 1'b0, "R8", "no read in reset", rd_req, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(fs === 1'b1 && ls === 1'b1, "R8", "top-left after reset", {fs, ls}, 2'b11);
        de_seen = 0;
        for (int c = 1; c < HT * VT; c++) begin
            @(negedge clk);
            if (de === 1'b1 || pix !== 8'h00) de_seen++;
        end
        chk(de_seen == 0, "R9", "first frame blank", de_seen, 0);
        push_frames(nf);
        consume();
    endtask

    initial begin
        session(3);
        // second reset taken partway through a visible line
        repeat (HT + 7) @(negedge clk);
        chk(de === 1'b1, "R9", "display running before mid-line reset", de, 1);
        session(2);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule